// File: doc/BRIEF.md
# Line-Scan Flat-Field Correction Pipeline

This block removes shading and sensor non-uniformity from a line-scan pixel stream. Each pixel position along a line has its own dark level and gain. For every valid pixel the block subtracts the dark level, scales the difference by an unsigned fixed-point gain, rounds back to the pixel width and limits the result to full scale. A pixel with start-of-line set resets the position counter. Each following valid pixel moves to the next stored coefficient pair.

Several taps share one position counter and one control pipeline. Each tap has its own datapath and its own coefficient store. Software fills the stores through a single write port before a line is acquired. The pixel depth (8, 10 or 12 bits) is chosen at run time with a mode input. The result appears a fixed three cycles after the pixel. A new pixel may be presented on every cycle.

Top module: `ffc_pipe`

## Requirements
- R1: `mode_sel` selects the depth: 0 means 8-bit, 1 means 10-bit, 2 and 3 both mean 12-bit. Tap t uses bits `[12t+11:12t]` of `in_pix` and `out_pix`. Narrower pixels use the low bits of that field, input bits above the depth are ignored, and output bits above the depth are zero.
- R2: The result is `floor(((raw - off) * gain + 2^(F-1)) / 2^F)`, which rounds half up. F is 8 in 8-bit mode and 12 otherwise.
- R3: When raw is not above the offset, the difference is taken as zero and the result is 0.
- R4: A result above `2^W - 1`, where W is the selected depth, is replaced by `2^W - 1`.
- R5: In 8-bit mode only offset bits [5:0] and gain bits [9:0] are used; the gain is read as 2 integer and 8 fraction bits. In 10- and 12-bit modes all 10 offset bits and all 14 gain bits are used; the gain is read as 2 integer and 12 fraction bits.
- R6: `out_valid` equals `in_valid` from three cycles earlier, and `out_sol` equals `in_valid && in_sol` from three cycles earlier. Pixels are accepted on consecutive cycles.
- R7: A valid pixel with `in_sol` uses coefficient index 0. Each later valid pixel uses the next index. Idle cycles do not advance the index. After index LINE_LEN-1 the index wraps to 0.
- R8: When `coef_we` is set, the pair (`coef_off`, `coef_gain`) is written to entry `coef_addr` of tap `coef_tap`. A pixel presented on the following cycle or later already uses the new pair.
- R9: Each tap has its own coefficient store. A write to one tap leaves the other taps' results unchanged.
- R10: While `rst` is high, `out_valid`, `out_sol` and `out_pix` become 0 and the index returns to 0. After reset, a valid pixel without `in_sol` uses index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Pixel depth select |
| in_valid | input | 1 | Input pixel qualifier |
| in_sol | input | 1 | Start of line, meaningful when valid |
| in_pix | input | 12*TAPS | Raw pixels, one 12-bit field per tap |
| coef_we | input | 1 | Coefficient write strobe |
| coef_tap | input | TAPW | Tap selected for the write |
| coef_addr | input | IDXW | Pixel index selected for the write |
| coef_off | input | 10 | Dark offset to write |
| coef_gain | input | 14 | Gain to write |
| out_valid | output | 1 | Output pixel qualifier |
| out_sol | output | 1 | Delayed start of line |
| out_pix | output | 12*TAPS | Corrected pixels, one 12-bit field per tap |

## Verification
The bench builds the block with TAPS=2 and LINE_LEN=8. With an eight-entry line, a short stream can pass the last index, wrap back to 0, and then restart from a start-of-line marker in the middle of the line. Two taps are enough to show that coefficient stores are separate, because each tap is given different gains and offsets. A vector table covers each depth near full scale, below the offset, and at the exact half-LSB rounding point.

// File: rtl/ffc_pkg.sv
package ffc_pkg;

    localparam int PIX_W  = 12;
    localparam int OFF_W  = 10;
    localparam int GAIN_W = 14;
    localparam int PROD_W = PIX_W + GAIN_W;

    typedef enum logic [1:0] {
        DEPTH8     = 2'd0,
        DEPTH10    = 2'd1,
        DEPTH12    = 2'd2,
        DEPTH12_B  = 2'd3
    } depth_e;

    typedef struct packed {
        logic [OFF_W-1:0]  off;
        logic [GAIN_W-1:0] gain;
    } coef_t;

    typedef struct packed {
        logic   valid;
        logic   sol;
        depth_e depth;
    } ctl_t;

    function automatic logic [PIX_W-1:0] full_scale(depth_e d);
        case (d)
            DEPTH8:  return PIX_W'(255);
            DEPTH10: return PIX_W'(1023);
            default: return PIX_W'(4095);
        endcase
    endfunction

    function automatic logic [PIX_W-1:0] fit_raw(logic [PIX_W-1:0] raw, depth_e d);
        case (d)
            DEPTH8:  return {4'b0, raw[7:0]};
            DEPTH10: return {2'b0, raw[9:0]};
            default: return raw;
        endcase
    endfunction

    function automatic logic [OFF_W-1:0] fit_off(logic [OFF_W-1:0] off, depth_e d);
        return (d == DEPTH8) ? {4'b0, off[5:0]} : off;
    endfunction

    function automatic logic [GAIN_W-1:0] fit_gain(logic [GAIN_W-1:0] gain, depth_e d);
        return (d == DEPTH8) ? {4'b0, gain[9:0]} : gain;
    endfunction

    // Add half an LSB of the fraction, then drop the fraction bits.
    function automatic logic [PROD_W-1:0] round_shift(logic [PROD_W-1:0] prod, depth_e d);
        logic [PROD_W:0] sum;
        if (d == DEPTH8) begin
            sum = {1'b0, prod} + (PROD_W+1)'(128);
            return PROD_W'(sum >> 8);
        end
        sum = {1'b0, prod} + (PROD_W+1)'(2048);
        return PROD_W'(sum >> 12);
    endfunction

endpackage

// File: rtl/ffc_line_index.sv
module ffc_line_index
    import ffc_pkg::*;
#(
    parameter int LINE_LEN = 256,
    parameter int IDXW     = $clog2(LINE_LEN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid,
    input  logic            sol,
    output logic [IDXW-1:0] idx
);
    localparam logic [IDXW-1:0] LAST = IDXW'(LINE_LEN - 1);

    logic [IDXW-1:0] next_pos;

    // Start of line forces position 0 for the current pixel.
    assign idx = sol ? '0 : next_pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pos <= '0;
        end else if (valid) begin
            next_pos <= (idx == LAST) ? '0 : idx + IDXW'(1);
        end
    end
endmodule

// File: rtl/ffc_coef_bank.sv
module ffc_coef_bank
    import ffc_pkg::*;
#(
    parameter int LINE_LEN = 256,
    parameter int IDXW     = $clog2(LINE_LEN)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [IDXW-1:0] waddr,
    input  coef_t           wdata,
    input  logic [IDXW-1:0] raddr,
    output coef_t           rdata
);
    coef_t mem [LINE_LEN];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/ffc_lane.sv
module ffc_lane
    import ffc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] raw_in,
    input  coef_t            coef_s1,
    input  depth_e           depth_s1,
    input  depth_e           depth_s2,
    output logic [PIX_W-1:0] pix_out
);
    logic [PIX_W-1:0]  raw_s1;
    logic [PROD_W-1:0] prod_s2;

    logic [PIX_W-1:0]  r_m, o_m, diff;
    logic [GAIN_W-1:0] g_m;
    logic [PROD_W-1:0] rnd;
    logic [PIX_W-1:0]  fs;

    always_comb begin
        r_m  = fit_raw(raw_s1, depth_s1);
        o_m  = {2'b0, fit_off(coef_s1.off, depth_s1)};
        g_m  = fit_gain(coef_s1.gain, depth_s1);
        diff = (r_m > o_m) ? (r_m - o_m) : '0;
    end

    always_comb begin
        rnd = round_shift(prod_s2, depth_s2);
        fs  = full_scale(depth_s2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_s1  <= '0;
            prod_s2 <= '0;
            pix_out <= '0;
        end else begin
            raw_s1  <= raw_in;
            prod_s2 <= PROD_W'(diff) * PROD_W'(g_m);
            pix_out <= (rnd > PROD_W'(fs)) ? fs : rnd[PIX_W-1:0];
        end
    end
endmodule

// File: rtl/ffc_pipe.sv
module ffc_pipe
    import ffc_pkg::*;
#(
    parameter int TAPS     = 4,
    parameter int LINE_LEN = 256,
    localparam int IDXW    = $clog2(LINE_LEN),
    localparam int TAPW    = (TAPS > 1) ? $clog2(TAPS) : 1,
    localparam int BUS_W   = TAPS * PIX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              in_valid,
    input  logic              in_sol,
    input  logic [BUS_W-1:0]  in_pix,
    input  logic              coef_we,
    input  logic [TAPW-1:0]   coef_tap,
    input  logic [IDXW-1:0]   coef_addr,
    input  logic [OFF_W-1:0]  coef_off,
    input  logic [GAIN_W-1:0] coef_gain,
    output logic              out_valid,
    output logic              out_sol,
    output logic [BUS_W-1:0]  out_pix
);
    ctl_t            ctl_s1, ctl_s2, ctl_s3;
    logic [IDXW-1:0] rd_idx;
    coef_t           wr_pair;

    assign wr_pair = '{off: coef_off, gain: coef_gain};

    ffc_line_index #(.LINE_LEN(LINE_LEN), .IDXW(IDXW)) u_index (
        .clk   (clk),
        .rst   (rst),
        .valid (in_valid),
        .sol   (in_sol),
        .idx   (rd_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_s1 <= '0;
            ctl_s2 <= '0;
            ctl_s3 <= '0;
        end else begin
            ctl_s1 <= '{valid: in_valid, sol: in_valid & in_sol, depth: depth_e'(mode_sel)};
            ctl_s2 <= ctl_s1;
            ctl_s3 <= ctl_s2;
        end
    end

    assign out_valid = ctl_s3.valid;
    assign out_sol   = ctl_s3.sol;

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        coef_t pair_s1;
        logic  tap_we;

        assign tap_we = coef_we && (coef_tap == TAPW'(t));

        ffc_coef_bank #(.LINE_LEN(LINE_LEN), .IDXW(IDXW)) u_bank (
            .clk   (clk),
            .we    (tap_we),
            .waddr (coef_addr),
            .wdata (wr_pair),
            .raddr (rd_idx),
            .rdata (pair_s1)
        );

        ffc_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .raw_in   (in_pix[t*PIX_W +: PIX_W]),
            .coef_s1  (pair_s1),
            .depth_s1 (ctl_s1.depth),
            .depth_s2 (ctl_s2.depth),
            .pix_out  (out_pix[t*PIX_W +: PIX_W])
        );
    end
endmodule

// File: rtl/ffc_pipe_chk.sv
module ffc_pipe_chk
    import ffc_pkg::*;
#(
    parameter int TAPS = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic [1:0]            mode_sel,
    input logic                  in_valid,
    input logic                  in_sol,
    input logic                  out_valid,
    input logic                  out_sol,
    input logic [TAPS*PIX_W-1:0] out_pix
);
    logic [1:0] since_rst;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end
    assign warm = (since_rst == 2'd3);

    // R6
    valid_align_chk: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_valid == $past(in_valid, 3)));

    // R6
    sol_align_chk: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_sol == $past(in_valid && in_sol, 3)));

    // R6
    sol_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        out_sol |-> out_valid);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_sol && (out_pix == '0)));

    for (genvar t = 0; t < TAPS; t++) begin : g_rng
        // R4
        full_scale_chk: assert property (@(posedge clk) disable iff (rst)
            (warm && out_valid) |->
            (out_pix[t*PIX_W +: PIX_W] <= full_scale(depth_e'($past(mode_sel, 3)))));
    end
endmodule

bind ffc_pipe ffc_pipe_chk #(.TAPS(TAPS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .in_valid  (in_valid),
    .in_sol    (in_sol),
    .out_valid (out_valid),
    .out_sol   (out_sol),
    .out_pix   (out_pix)
);

// File: tb/ffc_pipe_test.sv
module ffc_pipe_test;
    import ffc_pkg::*;

    localparam int TAPS = 2;
    localparam int LL   = 8;
    localparam int NV   = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = '0;
    logic        in_valid = 1'b0, in_sol = 1'b0;
    logic [23:0] in_pix = '0;
    logic        coef_we = 1'b0;
    logic [0:0]  coef_tap = '0;
    logic [2:0]  coef_addr = '0;
    logic [9:0]  coef_off = '0;
    logic [13:0] coef_gain = '0;
    logic        out_valid, out_sol;
    logic [23:0] out_pix;

    always #4 clk = ~clk;

    ffc_pipe #(.TAPS(TAPS), .LINE_LEN(LL)) uut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .in_valid(in_valid), .in_sol(in_sol),
        .in_pix(in_pix), .coef_we(coef_we), .coef_tap(coef_tap), .coef_addr(coef_addr),
        .coef_off(coef_off), .coef_gain(coef_gain), .out_valid(out_valid),
        .out_sol(out_sol), .out_pix(out_pix)
    );

    // {mode, raw, offset, gain, expected tap-0 result}
    localparam logic [49:0] VEC [NV] = '{
        {2'd0, 12'd200,  10'd20,   14'h0100, 12'd180 },
        {2'd0, 12'd100,  10'd0,    14'h0180, 12'd150 },
        {2'd0, 12'd10,   10'd30,   14'h0200, 12'd0   },
        {2'd0, 12'd255,  10'd0,    14'h03FF, 12'd255 },
        {2'd0, 12'd3,    10'd0,    14'h0080, 12'd2   },
        {2'd0, 12'd1,    10'd0,    14'h007F, 12'd0   },
        {2'd1, 12'd1000, 10'd100,  14'h1000, 12'd900 },
        {2'd1, 12'd1023, 10'd0,    14'h2000, 12'd1023},
        {2'd1, 12'd7,    10'd0,    14'h0800, 12'd4   },
        {2'd2, 12'd4000, 10'd1000, 14'h1400, 12'd3750},
        {2'd2, 12'd4095, 10'd0,    14'h3FFF, 12'd4095},
        {2'd2, 12'd500,  10'd600,  14'h1000, 12'd0   },
        {2'd0, 12'hF64,  10'h3C5,  14'h3D00, 12'd95  },
        {2'd3, 12'd2048, 10'd48,   14'h1000, 12'd2000}
    };
    string vtag [NV] = '{"R1", "R2", "R3", "R4", "R2", "R2", "R2", "R4", "R2",
                         "R2", "R4", "R3", "R5", "R1"};

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic        hv [3];
    logic        hs [3];
    logic [11:0] h0 [3];
    logic [11:0] h1 [3];
    string       ht [3];
    int moff  [2][LL];
    int mgain [2][LL];
    int bidx = 0;

    function automatic int model(int raw, int off, int gain, int m);
        int w, f, r, o, g, d, y;
        w = (m == 0) ? 8 : (m == 1) ? 10 : 12;
        f = (m == 0) ? 8 : 12;
        r = raw & ((1 << w) - 1);
        o = (m == 0) ? (off & 63) : (off & 1023);
        g = (m == 0) ? (gain & 1023) : (gain & 16383);
        d = (r > o) ? r - o : 0;
        y = (d * g + (1 << (f - 1))) >> f;
        return (y > (1 << w) - 1) ? (1 << w) - 1 : y;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_hist();
        for (int i = 0; i < 3; i++) begin
            hv[i] = 0; hs[i] = 0; h0[i] = '0; h1[i] = '0; ht[i] = "R6";
        end
    endtask

    task automatic step(logic v, logic s, logic [1:0] m, logic [11:0] p0, logic [11:0] p1,
                        logic [11:0] e0, logic [11:0] e1, string tag,
                        logic we, logic wt, logic [2:0] wa, logic [9:0] wo, logic [13:0] wg);
        @(negedge clk);
        chk(ht[2], "out_valid", int'(out_valid), int'(hv[2]));
        chk(ht[2], "out_sol", int'(out_sol), int'(hs[2]));
        if (hv[2]) begin
            chk(ht[2], "tap0 pixel", int'(out_pix[11:0]), int'(h0[2]));
            chk(ht[2], "tap1 pixel", int'(out_pix[23:12]), int'(h1[2]));
        end
        for (int i = 2; i > 0; i--) begin
            hv[i] = hv[i-1]; hs[i] = hs[i-1]; h0[i] = h0[i-1]; h1[i] = h1[i-1]; ht[i] = ht[i-1];
        end
        hv[0] = v; hs[0] = v & s; h0[0] = e0; h1[0] = e1; ht[0] = tag;
        in_valid = v; in_sol = s; mode_sel = m; in_pix = {p1, p0};
        coef_we = we; coef_tap = wt; coef_addr = wa; coef_off = wo; coef_gain = wg;
    endtask

    task automatic wr(logic t, int a, int o, int g);
        moff[t][a] = o; mgain[t][a] = g;
        step(0, 0, 2'd0, '0, '0, '0, '0, "R8", 1, t, 3'(a), 10'(o), 14'(g));
    endtask

    task automatic idle();
        step(0, 0, 2'd0, '0, '0, '0, '0, "R6", 0, 0, '0, '0, '0);
    endtask

    task automatic px(logic v, logic s, logic [1:0] m, int r0, int r1, string tag);
        int u, e0, e1;
        e0 = 0; e1 = 0;
        if (v) begin
            u = s ? 0 : bidx;
            bidx = (u == LL - 1) ? 0 : u + 1;
            e0 = model(r0, moff[0][u], mgain[0][u], int'(m));
            e1 = model(r1, moff[1][u], mgain[1][u], int'(m));
        end
        step(v, s, m, 12'(r0), 12'(r1), 12'(e0), 12'(e1), tag, 0, 0, '0, '0, '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        clear_hist();
        repeat (3) @(negedge clk);
        chk("R10", "out_valid in reset", int'(out_valid), 0);
        chk("R10", "out_sol in reset", int'(out_sol), 0);
        chk("R10", "out_pix in reset", int'(out_pix), 0);
        rst = 1'b0;

        // Table walk: one corrected pixel per row at index 0.
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  m;
            logic [11:0] raw, ex;
            logic [9:0]  off;
            logic [13:0] gn;
            {m, raw, off, gn, ex} = VEC[i];
            wr(0, 0, int'(off), int'(gn));
            wr(1, 0, 5, (m == 2'd0) ? 'h100 : 'h1000);
            bidx = 1;
            step(1, 1, m, raw, raw ^ 12'h0A5, ex,
                 12'(model(int'(raw ^ 12'h0A5), 5, (m == 2'd0) ? 'h100 : 'h1000, int'(m))),
                 vtag[i], 0, 0, '0, '0, '0);
        end
        repeat (3) idle();

        // R7 / R9: distinct coefficients per index and per tap, wrap and restart.
        for (int a = 0; a < LL; a++) begin
            wr(0, a, a * 10, 'h1000);
            wr(1, a, 0, 'h1000 + a * 'h100);
        end
        px(1, 1, 2'd1, 500, 300, "R7");
        for (int k = 0; k < 4; k++) px(1, 0, 2'd1, 500, 300, "R6");
        px(0, 0, 2'd1, 0, 0, "R7");
        px(0, 1, 2'd1, 0, 0, "R7");
        for (int k = 0; k < 5; k++) px(1, 0, 2'd1, 500 + k, 300, "R7");
        px(1, 0, 2'd1, 777, 200, "R9");
        px(1, 1, 2'd2, 900, 900, "R7");
        px(1, 0, 2'd2, 900, 900, "R7");
        repeat (3) idle();

        // R8: rewrite entry 1 of tap 0, then use it on the very next cycle.
        wr(0, 1, 200, 'h0800);
        px(1, 1, 2'd1, 600, 600, "R8");
        px(1, 0, 2'd1, 600, 600, "R8");
        // R9: write to tap 1 only; tap 0 result at index 0 stays the same.
        wr(1, 0, 100, 'h2000);
        px(1, 1, 2'd1, 600, 600, "R9");
        repeat (3) idle();

        // R10: reset mid-line clears outputs and the position.
        px(1, 1, 2'd1, 400, 400, "R10");
        px(1, 0, 2'd1, 400, 400, "R10");
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_sol = 1'b0; coef_we = 1'b0;
        @(negedge clk);
        chk("R10", "out_valid after reset", int'(out_valid), 0);
        chk("R10", "out_pix after reset", int'(out_pix), 0);
        rst = 1'b0;
        clear_hist();
        bidx = 0;
        px(1, 0, 2'd1, 450, 450, "R10");
        px(1, 0, 2'd1, 450, 450, "R7");
        repeat (4) idle();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule